// File: doc/BRIEF.md
# Up/down binary/decade counter

A four-bit synchronous counter that steps once per rising clock edge. It counts either upward or downward. A mode input chooses the wrap points: full binary (0 to 15) or decimal decade (0 to 9). Counting happens only while the active-low enable is low.

A level-sensitive load input overrides everything else. While it is high, the count register takes the data inputs and the outputs show them, whether or not the clock toggles. Counting then resumes on the first qualifying clock edge after the load drops.

An active-low terminal-count output is decoded combinationally from the count, the enable, the direction and the mode. Chained counters use it to pass on a carry or a borrow. Internally the top decodes one of four named operations each cycle: LOAD, HOLD, UP and DOWN. The transitions are LOAD→any when the load is released, HOLD↔UP/DOWN as the enable toggles, and UP↔DOWN as the direction input changes.

Top module: `updown_bcd_counter`

## Requirements
- R1: With load=0 and ce_n=0, each rising clk edge with up=1 adds exactly one to q.
- R2: While load=1, q equals din at once and continuously, independent of clk and of every other control.
- R3: With load=0 and ce_n=1, q keeps its value across clk edges.
- R4: With load=0, ce_n=0 and up=0, each rising clk edge subtracts exactly one from q.
- R5: In binary mode (bin=1), counting up wraps 15→0 and counting down wraps 0→15.
- R6: In decade mode (bin=0), counting up wraps 9→0 and counting down wraps 0→9.
- R7: tc_n is 1 whenever ce_n is 1.
- R8: With ce_n=0, tc_n is 0 at q=15 when counting up in binary mode, and at q=0 when counting down in either mode.
- R9: In decade mode counting up with ce_n=0, tc_n is 0 exactly when q bit 0 and q bit 3 are both 1 (9, 11, 13, 15).
- R10: In decade mode, a count of 10 to 15 steps up by one, with 15→0, and steps down by one.
- R11: tc_n is combinational: a change on ce_n, up or bin changes it without waiting for a clock edge.
- R12: After load falls, the loaded value (din held stable across the release) is the starting point of the first counting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| load | input | 1 | Asynchronous parallel load, active high, overrides all |
| din | input | 4 | Parallel load data |
| ce_n | input | 1 | Count enable, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| bin | input | 1 | Mode: 1 binary 0–15, 0 decade 0–9 |
| q | output | 4 | Current count |
| tc_n | output | 1 | Terminal count, active low |

## Verification
A count step shows on q one rising edge after the enable and direction seen at that edge. The bench therefore drives inputs at the falling edge and compares q at the next falling edge, after exactly one register stage. Load and tc_n are combinational paths, so they are compared one time unit after the input change, with no clock edge in between. A reference model advances only on rising edges and recomputes tc_n from its own count on every comparison.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_HOLD = 2'd1,
        OP_UP   = 2'd2,
        OP_DOWN = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/cnt_step.sv
module cnt_step #(
    parameter int W       = 4,
    parameter int DEC_TOP = 9
) (
    input  logic [W-1:0] cur,
    input  logic         up,
    input  logic         bin,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] DEC_LAST = W'(DEC_TOP);
    localparam logic [W-1:0] ONE      = W'(1);

    always_comb begin
        if (up) begin
            if (!bin && cur == DEC_LAST) nxt = '0;
            else                         nxt = cur + ONE;
        end else begin
            if (!bin && cur == '0)       nxt = DEC_LAST;
            else                         nxt = cur - ONE;
        end
    end
endmodule

// File: rtl/cnt_tc.sv
module cnt_tc #(
    parameter int W = 4
) (
    input  logic [W-1:0] cur,
    input  logic         ce_n,
    input  logic         up,
    input  logic         bin,
    output logic         tc_n
);
    logic at_top;
    logic at_zero;

    always_comb begin
        at_zero = (cur == '0);
        if (bin) at_top = &cur;
        else     at_top = cur[0] & cur[W-1];
        if (ce_n)    tc_n = 1'b1;
        else if (up) tc_n = ~at_top;
        else         tc_n = ~at_zero;
    end
endmodule

// File: rtl/updown_bcd_counter.sv
module updown_bcd_counter #(
    parameter int W       = 4,
    parameter int DEC_TOP = 9
) (
    input  logic         clk,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         ce_n,
    input  logic         up,
    input  logic         bin,
    output logic [W-1:0] q,
    output logic         tc_n
);
    import cnt_pkg::*;

    cnt_op_e      op;
    logic [W-1:0] cnt_r;
    logic [W-1:0] nxt;

    always_comb begin
        if (load)      op = OP_LOAD;
        else if (ce_n) op = OP_HOLD;
        else if (up)   op = OP_UP;
        else           op = OP_DOWN;
    end

    cnt_step #(.W(W), .DEC_TOP(DEC_TOP)) u_step (
        .cur (cnt_r),
        .up  (up),
        .bin (bin),
        .nxt (nxt)
    );

    always_ff @(posedge clk or posedge load) begin
        if (load) begin
            cnt_r <= din;
        end else begin
            unique case (op)
                OP_LOAD: cnt_r <= din;
                OP_HOLD: cnt_r <= cnt_r;
                OP_UP,
                OP_DOWN: cnt_r <= nxt;
                default: cnt_r <= cnt_r;
            endcase
        end
    end

    always_comb begin
        unique case (op)
            OP_LOAD: q = din;
            default: q = cnt_r;
        endcase
    end

    cnt_tc #(.W(W)) u_tc (
        .cur  (q),
        .ce_n (ce_n),
        .up   (up),
        .bin  (bin),
        .tc_n (tc_n)
    );
endmodule

// File: rtl/cnt_chk.sv
module cnt_chk #(
    parameter int W       = 4,
    parameter int DEC_TOP = 9
) (
    input logic         clk,
    input logic         load,
    input logic [W-1:0] din,
    input logic         ce_n,
    input logic         up,
    input logic         bin,
    input logic [W-1:0] q,
    input logic         tc_n
);
    localparam logic [W-1:0] DEC_LAST = W'(DEC_TOP);

    // R2: outputs track the data inputs during load
    a_r2_load_follows: assert property (@(negedge clk) load |-> q == din);

    // R7: terminal count inactive when disabled
    a_r7_tc_idle: assert property (@(negedge clk) ce_n |-> tc_n);

    // R3: hold when disabled
    a_r3_hold: assert property (@(posedge clk) disable iff (load)
        ($past(!load) && $past(ce_n)) |-> q == $past(q));

    // R1: binary count up by one
    a_r1_step_up: assert property (@(posedge clk) disable iff (load)
        ($past(!load) && $past(!ce_n) && $past(up) && $past(bin))
        |-> q == $past(q) + W'(1));

    // R4: binary count down by one
    a_r4_step_down: assert property (@(posedge clk) disable iff (load)
        ($past(!load) && $past(!ce_n) && $past(!up) && $past(bin))
        |-> q == $past(q) - W'(1));

    // R6: decade up wrap
    a_r6_dec_wrap: assert property (@(posedge clk) disable iff (load)
        ($past(!load) && $past(!ce_n) && $past(up) && $past(!bin)
         && $past(q) == DEC_LAST) |-> q == '0);
endmodule

bind updown_bcd_counter cnt_chk #(.W(W), .DEC_TOP(DEC_TOP)) u_chk (
    .clk  (clk),
    .load (load),
    .din  (din),
    .ce_n (ce_n),
    .up   (up),
    .bin  (bin),
    .q    (q),
    .tc_n (tc_n)
);

// File: tb/sim_updown_bcd_counter.sv
module sim_updown_bcd_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       load = 1'b1;
    logic [3:0] din = 4'd0;
    logic       ce_n = 1'b1;
    logic       up = 1'b1;
    logic       bin = 1'b1;
    logic [3:0] q;
    logic       tc_n;

    int n_run = 0;
    int n_fail = 0;
    int model = 0;

    updown_bcd_counter u0 (
        .clk(clk), .load(load), .din(din), .ce_n(ce_n),
        .up(up), .bin(bin), .q(q), .tc_n(tc_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ref_next(int v, logic u, logic b);
        if (u) return (!b && v == 9) ? 0 : (v + 1) % 16;
        return (!b && v == 0) ? 9 : (v + 15) % 16;
    endfunction

    function automatic logic ref_tc(int v, logic c, logic u, logic b);
        if (c) return 1'b1;
        if (!u) return (v == 0) ? 1'b0 : 1'b1;
        if (b) return (v == 15) ? 1'b0 : 1'b1;
        return (v % 2 == 1 && v >= 8) ? 1'b0 : 1'b1;
    endfunction

    task automatic check(string tag);
        logic exp_tc;
        exp_tc = ref_tc(model, ce_n, up, bin);
        n_run++;
        if (int'(q) != model) begin
            n_fail++;
            $display("FAIL %s q actual=%0d expected=%0d", tag, q, model);
        end
        n_run++;
        if (tc_n !== exp_tc) begin
            n_fail++;
            $display("FAIL %s tc_n actual=%0b expected=%0b (q=%0d)", tag, tc_n, exp_tc, q);
        end
    endtask

    // one clock: model steps at the rising edge, compare at the falling edge
    task automatic tick(string tag);
        @(posedge clk);
        if (load) model = int'(din);
        else if (!ce_n) model = ref_next(model, up, bin);
        @(negedge clk);
        check(tag);
    endtask

    task automatic do_load(int v, string tag);
        load = 1'b1;
        din = 4'(v);
        model = v;
        #1;
        check(tag);
        @(negedge clk);
        load = 1'b0;
        #1;
        check(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R2 initial load of zero");
        load = 1'b0;
        ce_n = 1'b0;
        // R1 R5 R8: binary up through 15->0
        bin = 1'b1; up = 1'b1;
        for (int i = 0; i < 20; i++) tick("R1 R5 R8 binary up");
        // R4 R5 R8: binary down through 0->15
        up = 1'b0;
        #1; check("R11 direction flip");
        for (int i = 0; i < 20; i++) tick("R4 R5 R8 binary down");
        // R3 R7: hold
        ce_n = 1'b1;
        #1; check("R7 disabled");
        for (int i = 0; i < 5; i++) tick("R3 R7 hold");
        // R6 R9: decade
        do_load(0, "R2 load zero");
        ce_n = 1'b0; bin = 1'b0; up = 1'b1;
        for (int i = 0; i < 25; i++) tick("R6 R9 decade up");
        up = 1'b0;
        for (int i = 0; i < 25; i++) tick("R6 R8 decade down");
        // R10: decade from illegal values
        do_load(12, "R2 load 12");
        up = 1'b1;
        for (int i = 0; i < 6; i++) tick("R10 R9 decade up from 12");
        do_load(13, "R2 load 13");
        up = 1'b0;
        for (int i = 0; i < 6; i++) tick("R10 decade down from 13");
        // R2: load overrides clock and enable, follows din
        load = 1'b1; din = 4'd5; model = 5;
        #1; check("R2 load 5");
        for (int i = 0; i < 3; i++) begin
            tick("R2 load held over clock");
            din = 4'(7 + i); model = 7 + i;
            #1; check("R2 load follows din");
        end
        @(negedge clk);
        load = 1'b0; bin = 1'b1; up = 1'b1;
        #1; check("R12 release");
        tick("R12 first edge after release");
        // R11: tc changes without a clock edge
        do_load(15, "R2 load 15");
        #1; check("R8 tc at 15 up");
        up = 1'b0; #1; check("R11 up to down");
        up = 1'b1; #1; check("R11 down to up");
        bin = 1'b0; #1; check("R11 mode to decade R9");
        ce_n = 1'b1; #1; check("R11 R7 disable");
        ce_n = 1'b0;
        // sweep: every start value, mode and direction
        for (int b = 0; b < 2; b++)
            for (int u = 0; u < 2; u++)
                for (int v = 0; v < 16; v++) begin
                    bin = 1'(b); up = 1'(u);
                    do_load(v, "R2 sweep load");
                    tick("R1 R4 R5 R6 R10 sweep");
                    tick("R1 R4 R5 R6 R10 sweep");
                end
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule